// File: doc/BRIEF.md
# Memory Card Early Address Decoder

This block sits at the slave end of a 32-bit memory card on a parallel expansion bus. The bus puts a pipelined copy of the address on early lines, ahead of the latched address. The block samples those early lines together with the active-low byte enables and the memory/IO and write/read cycle lines. It decides whether the card owns the cycle in time for the card to start a DRAM access early. The early lines carry the address in doubleword form (bits 31..2). On their upper part the electrical levels are inverted: a low level stands for a logical one. The block restores the true value before any comparison.

Along with the select decision, the block keeps the DRAM row of the last access that selected the card. It flags a row hit when the next selected access falls in the same row, so a page-mode controller can skip the row precharge. When the card is configured as burst-capable, the block drives the active-low slave-burst line for selected cycles. It also latches the master's active-low answer, and reports that a burst has been agreed only when both sides have signalled. The card's window is a naturally aligned power-of-two region. Its base and size come from configuration inputs.

Top module: `mem_early_decode`

## Requirements
- R1: While reset is high and on the first clock after it, `sel_q`, `row_hit_q`, `wr_q`, `burst_ok` are 0, `be_q` is 4'b0000 and `sburst_n` is 1.
- R2: Address bits 31..24 of `bus_addr` are inverted on the bus (logical = ~pin). Bits 23..2 are true. Only the restored logical address is compared with `cfg_base`.
- R3: On a clock with `cycle_start` high, the card is selected when bits 31..k of the logical address equal those of `cfg_base`. Here k = max(`cfg_size_log2`, 12), so the window is 2^k bytes. `sel_q` shows the result from the next clock on.
- R4: A cycle with `bus_mio` low (an I/O cycle) never selects the card.
- R5: A cycle with `bus_be_n` = 4'b1111 (no byte enabled) does not select the card and leaves the row-tracking state unchanged.
- R6: `row_hit_q` is 1 after a selected cycle only if the previous selected cycle hit the same row (logical address bits 21..11) and no invalidating cycle came in between.
- R7: A strobed cycle that enables some byte but does not select the card invalidates row tracking. So does reset. The next selected cycle then reports no row hit.
- R8: `sburst_n` goes to 0 after a selected cycle when `cfg_burst_en` was 1 at the strobe, whatever the level of `bus_mburst_n`. Otherwise it goes to 1.
- R9: `burst_ok` is cleared on each strobe. It is set on a later clock without strobe where `sburst_n` is 0 and `bus_mburst_n` is 0, and it stays set until the next strobe.
- R10: After a selected cycle, `wr_q` equals `bus_wr` (1 = write) and `be_q` equals ~`bus_be_n` (bit n = byte n enabled). After an unselected cycle both are 0.
- R11: On clocks with `cycle_start` low, `sel_q`, `row_hit_q`, `wr_q`, `be_q` and `sburst_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_start | input | 1 | Qualifies the early address on this clock |
| bus_addr | input | 30 | Early address bits 31..2, upper byte inverted |
| bus_be_n | input | 4 | Byte enables, active low |
| bus_mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_mburst_n | input | 1 | Master burst answer, active low |
| cfg_base | input | 30 | Window base, logical address bits 31..2 |
| cfg_size_log2 | input | 6 | log2 of window size in bytes (minimum 12) |
| cfg_burst_en | input | 1 | Card accepts burst cycles |
| sel_q | output | 1 | Card selected for the current cycle |
| row_hit_q | output | 1 | Selected access is in the same DRAM row as the last one |
| wr_q | output | 1 | Selected cycle is a write |
| be_q | output | 4 | Active-high byte enables of the selected cycle |
| sburst_n | output | 1 | Slave burst capability, active low |
| burst_ok | output | 1 | Burst agreed by both sides |

## Verification
The bench places addresses on both sides of each window edge, and it sets the size below its minimum. A wrong mask would admit the neighbouring block or drop the top doubleword. It sends the same logical address with and without the upper-byte inversion. A decoder that skips the inversion then selects on the wrong one. Row tracking is tested across no-byte cycles, which must keep the row, and across misses and I/O cycles, which must clear it. A design that mixed these up would report stale page hits or lose valid ones. The master-burst line is also driven low on unselected cycles and while slave burst is disabled, to catch a design that agrees a burst on one side's signal alone.

// File: rtl/mem_early_decode_pkg.sv
package mem_early_decode_pkg;
  localparam int BE_W = 4;

  typedef struct packed {
    logic            sel;
    logic            wr;
    logic [BE_W-1:0] be;
  } cycle_info_t;

  function automatic logic [5:0] clamp_size(input logic [5:0] req, input logic [5:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction
endpackage

// File: rtl/addr_restore.sv
module addr_restore #(
  parameter int ADDR_W  = 32,
  parameter int INV_LSB = 24
) (
  input  logic [ADDR_W-1:2] raw_addr,
  input  logic [3:0]        be_n,
  output logic [ADDR_W-1:2] log_addr,
  output logic [3:0]        be,
  output logic              any_be
);
  for (genvar i = 2; i < ADDR_W; i++) begin : g_bit
    if (i >= INV_LSB) begin : g_inv
      assign log_addr[i] = ~raw_addr[i];
    end else begin : g_true
      assign log_addr[i] = raw_addr[i];
    end
  end

  assign be     = ~be_n;
  assign any_be = |be;
endmodule

// File: rtl/window_match.sv
module window_match #(
  parameter int ADDR_W       = 32,
  parameter int SZ_W         = 6,
  parameter int MIN_WIN_LOG2 = 12
) (
  input  logic [ADDR_W-1:2] addr,
  input  logic [ADDR_W-1:2] base,
  input  logic [SZ_W-1:0]   size_log2,
  output logic              match
);
  localparam logic [SZ_W-1:0] FLOOR = SZ_W'(MIN_WIN_LOG2);

  logic [SZ_W-1:0]   eff_size;
  logic [ADDR_W-1:2] diff;

  assign eff_size = (size_log2 < FLOOR) ? FLOOR : size_log2;

  for (genvar i = 2; i < ADDR_W; i++) begin : g_cmp
    assign diff[i] = (SZ_W'(i) >= eff_size) & (addr[i] ^ base[i]);
  end

  assign match = ~|diff;
endmodule

// File: rtl/row_tracker.sv
module row_tracker #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             acc_sel,
  input  logic             acc_skip,
  input  logic [ROW_W-1:0] row_in,
  output logic             hit_q
);
  logic [ROW_W-1:0] row_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else if (strobe) begin
      hit_q <= acc_sel & valid_q & (row_in == row_q);
      if (acc_sel) begin
        row_q   <= row_in;
        valid_q <= 1'b1;
      end else if (!acc_skip) begin
        valid_q <= 1'b0;
      end
    end
  end

  a_r6_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (strobe && acc_sel && !valid_q) |=> !hit_q);

  a_r5_skip_keeps_row: assert property (@(posedge clk) disable iff (rst)
    (strobe && acc_skip && !acc_sel) |=> ($stable(row_q) && $stable(valid_q)));
endmodule

// File: rtl/burst_resp.sv
module burst_resp (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic sel_now,
  input  logic burst_en,
  input  logic mburst,
  output logic sburst_n,
  output logic agreed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sburst_n <= 1'b1;
      agreed   <= 1'b0;
    end else if (strobe) begin
      sburst_n <= ~(sel_now & burst_en);
      agreed   <= 1'b0;
    end else if (!sburst_n && mburst) begin
      agreed <= 1'b1;
    end
  end

  a_r9_agree_needs_slave: assert property (@(posedge clk) disable iff (rst)
    agreed |-> !sburst_n);

  a_r9_clear_on_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !agreed);
endmodule

// File: rtl/mem_early_decode.sv
module mem_early_decode
  import mem_early_decode_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int INV_LSB      = 24,
  parameter int SZ_W         = 6,
  parameter int MIN_WIN_LOG2 = 12,
  parameter int ROW_LSB      = 11,
  parameter int ROW_W        = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_start,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [3:0]        bus_be_n,
  input  logic              bus_mio,
  input  logic              bus_wr,
  input  logic              bus_mburst_n,
  input  logic [ADDR_W-1:2] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size_log2,
  input  logic              cfg_burst_en,
  output logic              sel_q,
  output logic              row_hit_q,
  output logic              wr_q,
  output logic [3:0]        be_q,
  output logic              sburst_n,
  output logic              burst_ok
);
  localparam int ROW_MSB = ROW_LSB + ROW_W - 1;

  logic [ADDR_W-1:2] log_addr;
  logic [3:0]        be_act;
  logic              any_be;
  logic              win_hit;
  cycle_info_t       now_info;
  cycle_info_t       cyc_q;

  addr_restore #(.ADDR_W(ADDR_W), .INV_LSB(INV_LSB)) u_restore (
    .raw_addr (bus_addr),
    .be_n     (bus_be_n),
    .log_addr (log_addr),
    .be       (be_act),
    .any_be   (any_be)
  );

  window_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_WIN_LOG2(MIN_WIN_LOG2)) u_match (
    .addr      (log_addr),
    .base      (cfg_base),
    .size_log2 (cfg_size_log2),
    .match     (win_hit)
  );

  always_comb begin
    now_info.sel = bus_mio & any_be & win_hit;
    now_info.wr  = now_info.sel & bus_wr;
    now_info.be  = now_info.sel ? be_act : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
    end else if (cycle_start) begin
      cyc_q <= now_info;
    end
  end

  assign sel_q = cyc_q.sel;
  assign wr_q  = cyc_q.wr;
  assign be_q  = cyc_q.be;

  row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk      (clk),
    .rst      (rst),
    .strobe   (cycle_start),
    .acc_sel  (now_info.sel),
    .acc_skip (~any_be),
    .row_in   (log_addr[ROW_MSB:ROW_LSB]),
    .hit_q    (row_hit_q)
  );

  burst_resp u_burst (
    .clk      (clk),
    .rst      (rst),
    .strobe   (cycle_start),
    .sel_now  (now_info.sel),
    .burst_en (cfg_burst_en),
    .mburst   (~bus_mburst_n),
    .sburst_n (sburst_n),
    .agreed   (burst_ok)
  );

  a_r4_io_never_selects: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && !bus_mio) |=> !sel_q);

  a_r5_no_bytes_no_select: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && (bus_be_n == 4'hF)) |=> !sel_q);

  a_r6_hit_implies_sel: assert property (@(posedge clk) disable iff (rst)
    row_hit_q |-> sel_q);

  a_r8_sburst_implies_sel: assert property (@(posedge clk) disable iff (rst)
    !sburst_n |-> sel_q);

  a_r11_hold_sel: assert property (@(posedge clk) disable iff (rst)
    !cycle_start |=> ($stable(sel_q) && $stable(row_hit_q) && $stable(be_q)));
endmodule

// File: tb/mem_early_decode_bench.sv
module mem_early_decode_bench;
  localparam int          ADDR_W   = 32;
  localparam logic [31:0] INV_MASK = 32'hFF00_0000;
  localparam logic [31:0] BASE     = 32'h1234_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cycle_start = 1'b0;
  logic [31:2] bus_addr = '0;
  logic [3:0]  bus_be_n = 4'hF;
  logic        bus_mio = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_mburst_n = 1'b1;
  logic [31:2] cfg_base = BASE[31:2];
  logic [5:0]  cfg_size_log2 = 6'd16;
  logic        cfg_burst_en = 1'b0;
  logic        sel_q, row_hit_q, wr_q, sburst_n, burst_ok;
  logic [3:0]  be_q;

  int vectors = 0;
  int misses = 0;
  string ph = "R1";

  always #10 clk = ~clk;

  mem_early_decode u_mem_early_decode (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_mio(bus_mio), .bus_wr(bus_wr),
    .bus_mburst_n(bus_mburst_n), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
    .cfg_burst_en(cfg_burst_en), .sel_q(sel_q), .row_hit_q(row_hit_q), .wr_q(wr_q),
    .be_q(be_q), .sburst_n(sburst_n), .burst_ok(burst_ok)
  );

  // behavioural reference
  bit        e_sel, e_hit, e_wr, e_sb, e_ok;
  bit [3:0]  e_be;
  bit        m_valid;
  int        m_row;

  always @(posedge clk) begin
    if (rst) begin
      e_sel = 0; e_hit = 0; e_wr = 0; e_sb = 0; e_ok = 0; e_be = 0;
      m_valid = 0; m_row = 0;
    end else if (cycle_start) begin
      logic [31:0] la;
      int k;
      logic [31:0] mask;
      bit hit;
      int row;
      la   = {bus_addr, 2'b00} ^ INV_MASK;
      k    = (cfg_size_log2 < 12) ? 12 : int'(cfg_size_log2);
      mask = (k >= 32) ? 32'h0 : ~((32'h1 << k) - 32'h1);
      hit  = bus_mio && (bus_be_n != 4'hF) && (((la ^ {cfg_base, 2'b00}) & mask) == 0);
      row  = int'((la >> 11) & 32'h7FF);
      e_sel = hit;
      e_wr  = hit && bus_wr;
      e_be  = hit ? ~bus_be_n : 4'h0;
      e_hit = hit && m_valid && (row == m_row);
      e_sb  = hit && cfg_burst_en;
      e_ok  = 0;
      if (hit) begin m_row = row; m_valid = 1; end
      else if (bus_be_n != 4'hF) m_valid = 0;
    end else if (e_sb && !bus_mburst_n) begin
      e_ok = 1;
    end
  end

  task automatic cmp1(string what, int act, int exp, string tag);
    if (act != exp) begin
      misses++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h at %0t", tag, ph, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      cmp1("sel_q", sel_q, e_sel, "R3");
      cmp1("row_hit_q", row_hit_q, e_hit, "R6");
      cmp1("wr_q", wr_q, e_wr, "R10");
      cmp1("be_q", be_q, e_be, "R10");
      cmp1("sburst_n", sburst_n, !e_sb, "R8");
      cmp1("burst_ok", burst_ok, e_ok, "R9");
    end
  end

  task automatic cyc(bit st, logic [31:0] la, logic [3:0] ben, bit mio, bit wr, bit mb);
    @(negedge clk);
    cycle_start  = st;
    bus_addr     = (la ^ INV_MASK) >> 2;
    bus_be_n     = ben;
    bus_mio      = mio;
    bus_wr       = wr;
    bus_mburst_n = mb;
  endtask

  task automatic acc(logic [31:0] la);
    cyc(1, la, 4'h0, 1, 0, 1);
  endtask

  initial begin
    #(20 * 200000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values checked on first compare
    cyc(0, 0, 4'hF, 0, 0, 1);
    ph = "R2";
    acc(32'h1234_0100);
    // raw upper byte equal to logical value instead of inverted
    @(negedge clk);
    cycle_start = 1; bus_addr = 32'h1234_0100 >> 2; bus_be_n = 4'h0; bus_mio = 1;
    ph = "R3";
    acc(32'h1234_0000); acc(32'h1234_FFFC); acc(32'h1235_0000); acc(32'h1233_FFFC);
    cyc(0, 0, 4'h0, 1, 0, 1);
    cfg_size_log2 = 6'd20;
    acc(32'h123F_FFFC); acc(32'h1230_0000); acc(32'h1240_0000);
    cfg_size_log2 = 6'd3;
    acc(32'h1234_0FFC); acc(32'h1234_1000);
    cfg_size_log2 = 6'd16;
    ph = "R4";
    cyc(1, 32'h1234_0200, 4'h0, 0, 1, 1);
    ph = "R5";
    acc(32'h1234_0300); cyc(1, 32'h1234_0304, 4'hF, 1, 0, 1); acc(32'h1234_0308);
    cyc(1, 32'h1234_0304, 4'hF, 0, 0, 1); acc(32'h1234_030C);
    ph = "R6";
    acc(32'h1234_0000); acc(32'h1234_0004); acc(32'h1234_0800); acc(32'h1234_0804);
    ph = "R7";
    acc(32'h1234_0900); acc(32'h5555_0000); acc(32'h1234_0904);
    cyc(1, 32'h1234_0908, 4'h0, 0, 0, 1); acc(32'h1234_090C);
    ph = "R8";
    cfg_burst_en = 1;
    cyc(1, 32'h1234_1000, 4'h0, 1, 0, 0);
    ph = "R9";
    cyc(0, 32'h1234_1000, 4'h0, 1, 0, 1); cyc(0, 32'h1234_1000, 4'h0, 1, 0, 0);
    cyc(0, 32'h1234_1000, 4'h0, 1, 0, 1);
    cyc(1, 32'h7000_0000, 4'h0, 1, 0, 0); cyc(0, 0, 4'h0, 1, 0, 0);
    cfg_burst_en = 0;
    cyc(1, 32'h1234_1000, 4'h0, 1, 0, 0); cyc(0, 0, 4'h0, 1, 0, 0);
    ph = "R10";
    cyc(1, 32'h1234_2000, 4'hA, 1, 1, 1); cyc(1, 32'h1234_2004, 4'h7, 1, 0, 1);
    cyc(1, 32'h9234_2004, 4'h0, 1, 1, 1);
    ph = "R11";
    acc(32'h1234_2008);
    for (int i = 0; i < 4; i++) cyc(0, 32'h4000_0000 + i, 4'hF, 0, 1, 0);
    ph = "random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] la;
      int r;
      r  = $urandom_range(0, 9);
      la = (r < 7) ? (BASE | ($urandom_range(0, 3) << 11) | ($urandom_range(0, 7) << 2))
                   : $urandom;
      if (i % 200 == 0) cfg_burst_en = $urandom_range(0, 1);
      cyc($urandom_range(0, 3) != 0, la, ($urandom_range(0, 5) == 0) ? 4'hF : 4'($urandom),
          $urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom));
    end
    cyc(0, 0, 4'hF, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule